// File: doc/BRIEF.md
# PLL Factor Update Sequencer

This block moves a CPU clock PLL from the factor set it currently runs with to a newly requested one. It does this without the clock output ever rising above the faster of the two operating points. The PLL output has three parts. A power-of-two pre-divider `P` and a post-divider `M` act on the very next clock. The feedback multiplier, formed from `N` and `K`, makes the VCO drift towards its new rate over many cycles and then raise a lock indication. If a divider is lowered while the VCO still runs at its old rate, the output overshoots. The sequencer avoids this by ordering the writes and by timing the waits between them.

A requester presents `N`, `K`, `M` and `P` and pulses `start`. The block holds the factors it has applied so far and drives them to the PLL control fields. Each divider that must grow is written alone, before the multiplier, and is followed by a long settle wait. `N` and `K` are then written together, followed by a short wait and a wait for lock. After lock, each divider that must shrink is written alone, `M` before `P`, and each is followed by a long settle wait. A divider that does not change is skipped, along with its wait. If lock does not arrive within a limit set at run time, the lock wait gives up.

Top module: `pll_factor_sequencer`

## Requirements
- R1: While reset is held and after it is released, the applied factors equal the parameters `RST_N`, `RST_K`, `RST_M`, `RST_P`, and `busy`, `done`, `lock_fail` and `reject` are 0.
- R2: If the requested `P` exceeds the applied `P`, the first write changes `P` alone. The next write follows exactly `SETTLE_LONG` cycles later.
- R3: If the requested `M` exceeds the applied `M`, `M` is written alone, after any `P` raise and before `N`/`K`. The next write follows exactly `SETTLE_LONG` cycles later.
- R4: `N` and `K` are written together in one write, in which neither divider changes. After it come a wait of `SETTLE_SHORT` cycles and then a wait for `pll_lock`.
- R5: A decrease of `M` is written only after `pll_lock` has been seen high, and it is followed by `SETTLE_LONG` cycles.
- R6: A decrease of `P` is the last write of a run. It comes exactly `SETTLE_LONG` cycles after an `M` decrease when both occur.
- R7: A divider that is neither raised nor lowered causes no write and no wait. Each divider step performed makes the run exactly `SETTLE_LONG` cycles longer.
- R8: Every write leaves the fields it does not target unchanged. `P` and `M` never change in the same cycle. At the end of a run the applied factors equal the request.
- R9: The `P` field is 3 bits wide, and only the values 0 to `P_MAX` (default 3) are valid. A request with a larger `P` (4 to 7) is refused: `reject` pulses for one cycle, `busy` stays 0 and the applied factors do not change.
- R10: A `start` that arrives while `busy` is 1 is ignored. The run in progress completes with its own request, and it gives one `done`.
- R11: `done` is high for exactly one cycle: the first cycle after the last wait, in which `busy` is already 0.
- R12: If `pll_lock` stays low for `lock_limit`+1 cycles of the lock wait, `lock_fail` pulses and the block returns to idle. No `done` is given, and the pending divider decreases are not written.
- R13: With a PLL whose VCO keeps its old rate until lock, the output frequency never exceeds the larger of the old and new operating points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| req_n | input | NW | Requested N multiplier factor |
| req_k | input | KW | Requested K multiplier factor |
| req_m | input | MW | Requested post-divider M |
| req_p | input | PW | Requested pre-divider exponent P |
| lock_limit | input | LOCK_W | Lock wait limit in cycles (timeout after lock_limit+1) |
| pll_lock | input | 1 | Lock indication from the PLL |
| fac_n | output | NW | Applied N factor |
| fac_k | output | KW | Applied K factor |
| fac_m | output | MW | Applied M factor |
| fac_p | output | PW | Applied P factor |
| busy | output | 1 | A factor change is in progress |
| done | output | 1 | One-cycle pulse at the end of a successful run |
| lock_fail | output | 1 | One-cycle pulse when the lock wait times out |
| reject | output | 1 | One-cycle pulse when a request carries an invalid P |

## Verification
The bench builds the block with `SETTLE_LONG` = 40 and `SETTLE_SHORT` = 4 in place of the long default waits, so that every ordering of raises, lowers and skipped steps completes in a few hundred cycles. A behavioural PLL model holds its old VCO rate for 25 cycles after each multiplier change, which brings the overshoot case within reach: lowering both dividers while reducing the multiplier. The bench measures the gap between writes and the length of each run exactly. A lock limit of 10 against a lock that is forced low exercises the timeout path.

// File: rtl/pllseq_pkg.sv
`timescale 1ns/1ps
package pllseq_pkg;

    // Sequencer phases; the order of the raise/lower phases is the update order.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PLAN = 3'd1,
        PH_P_UP = 3'd2,
        PH_M_UP = 3'd3,
        PH_NK   = 3'd4,
        PH_LOCK = 3'd5,
        PH_M_DN = 3'd6,
        PH_P_DN = 3'd7
    } phase_e;

endpackage

// File: rtl/pllseq_timer.sv
`timescale 1ns/1ps
module pllseq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // An expired wait stays expired until the next load.
    assert_hold_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/pllseq_field_cmp.sv
`timescale 1ns/1ps
module pllseq_field_cmp #(
    parameter int W = 2
) (
    input  logic [W-1:0] want,
    input  logic [W-1:0] have,
    output logic         raise,
    output logic         lower
);

    assign raise = (want > have);
    assign lower = (want < have);

endmodule

// File: rtl/pll_factor_sequencer.sv
`timescale 1ns/1ps
module pll_factor_sequencer
    import pllseq_pkg::*;
#(
    parameter int NW           = 5,
    parameter int KW           = 2,
    parameter int MW           = 2,
    parameter int PW           = 3,
    parameter int P_MAX        = 3,
    parameter int SETTLE_LONG  = 2000,
    parameter int SETTLE_SHORT = 20,
    parameter int LOCK_W       = 16,
    parameter int RST_N        = 16,
    parameter int RST_K        = 0,
    parameter int RST_M        = 0,
    parameter int RST_P        = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NW-1:0]     req_n,
    input  logic [KW-1:0]     req_k,
    input  logic [MW-1:0]     req_m,
    input  logic [PW-1:0]     req_p,
    input  logic [LOCK_W-1:0] lock_limit,
    input  logic              pll_lock,
    output logic [NW-1:0]     fac_n,
    output logic [KW-1:0]     fac_k,
    output logic [MW-1:0]     fac_m,
    output logic [PW-1:0]     fac_p,
    output logic              busy,
    output logic              done,
    output logic              lock_fail,
    output logic              reject
);

    localparam int LONG_W  = $clog2(SETTLE_LONG + 1);
    localparam int SHORT_W = $clog2(SETTLE_SHORT + 1);
    localparam int WAIT_W  = (LONG_W > SHORT_W) ? LONG_W : SHORT_W;
    localparam int TW      = (WAIT_W > LOCK_W) ? WAIT_W : LOCK_W;
    localparam logic [TW-1:0] LONG_LD  = TW'(SETTLE_LONG - 1);
    localparam logic [TW-1:0] SHORT_LD = TW'(SETTLE_SHORT - 1);
    localparam logic [PW-1:0] P_TOP    = PW'(P_MAX);

    typedef struct packed {
        phase_e        ph;
        logic [NW-1:0] tgt_n;
        logic [KW-1:0] tgt_k;
        logic [MW-1:0] tgt_m;
        logic [PW-1:0] tgt_p;
        logic [NW-1:0] app_n;
        logic [KW-1:0] app_k;
        logic [MW-1:0] app_m;
        logic [PW-1:0] app_p;
        logic          done;
        logic          fail;
        logic          rej;
    } seq_t;

    seq_t st_d, st_q;

    logic          p_up, p_dn, m_up, m_dn;
    logic          tm_load, tm_zero;
    logic [TW-1:0] tm_val;
    logic          adv;
    phase_e        go;

    pllseq_field_cmp #(.W(PW)) u_cmp_p (
        .want  (st_q.tgt_p),
        .have  (st_q.app_p),
        .raise (p_up),
        .lower (p_dn)
    );

    pllseq_field_cmp #(.W(MW)) u_cmp_m (
        .want  (st_q.tgt_m),
        .have  (st_q.app_m),
        .raise (m_up),
        .lower (m_dn)
    );

    pllseq_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .zero     (tm_zero)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.fail = 1'b0;
        st_d.rej  = 1'b0;
        adv       = 1'b0;
        go        = PH_IDLE;
        tm_load   = 1'b0;
        tm_val    = '0;

        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (req_p > P_TOP) begin
                        st_d.rej = 1'b1;
                    end else begin
                        st_d.tgt_n = req_n;
                        st_d.tgt_k = req_k;
                        st_d.tgt_m = req_m;
                        st_d.tgt_p = req_p;
                        st_d.ph    = PH_PLAN;
                    end
                end
            end
            PH_PLAN: begin
                adv = 1'b1;
                go  = p_up ? PH_P_UP : (m_up ? PH_M_UP : PH_NK);
            end
            PH_P_UP: begin
                if (tm_zero) begin
                    adv = 1'b1;
                    go  = m_up ? PH_M_UP : PH_NK;
                end
            end
            PH_M_UP: begin
                if (tm_zero) begin
                    adv = 1'b1;
                    go  = PH_NK;
                end
            end
            PH_NK: begin
                if (tm_zero) begin
                    adv = 1'b1;
                    go  = PH_LOCK;
                end
            end
            PH_LOCK: begin
                if (pll_lock) begin
                    adv = 1'b1;
                    go  = m_dn ? PH_M_DN : (p_dn ? PH_P_DN : PH_IDLE);
                end else if (tm_zero) begin
                    st_d.fail = 1'b1;
                    st_d.ph   = PH_IDLE;
                end
            end
            PH_M_DN: begin
                if (tm_zero) begin
                    adv = 1'b1;
                    go  = p_dn ? PH_P_DN : PH_IDLE;
                end
            end
            PH_P_DN: begin
                if (tm_zero) begin
                    adv = 1'b1;
                    go  = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase

        // Common entry action for the phase being entered.
        if (adv) begin
            st_d.ph = go;
            case (go)
                PH_P_UP, PH_P_DN: begin
                    st_d.app_p = st_q.tgt_p;
                    tm_load    = 1'b1;
                    tm_val     = LONG_LD;
                end
                PH_M_UP, PH_M_DN: begin
                    st_d.app_m = st_q.tgt_m;
                    tm_load    = 1'b1;
                    tm_val     = LONG_LD;
                end
                PH_NK: begin
                    st_d.app_n = st_q.tgt_n;
                    st_d.app_k = st_q.tgt_k;
                    tm_load    = 1'b1;
                    tm_val     = SHORT_LD;
                end
                PH_LOCK: begin
                    tm_load = 1'b1;
                    tm_val  = TW'(lock_limit);
                end
                PH_IDLE: st_d.done = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ph    <= PH_IDLE;
            st_q.app_n <= NW'(RST_N);
            st_q.app_k <= KW'(RST_K);
            st_q.app_m <= MW'(RST_M);
            st_q.app_p <= PW'(RST_P);
            st_q.tgt_n <= NW'(RST_N);
            st_q.tgt_k <= KW'(RST_K);
            st_q.tgt_m <= MW'(RST_M);
            st_q.tgt_p <= PW'(RST_P);
        end else begin
            st_q <= st_d;
        end
    end

    assign fac_n     = st_q.app_n;
    assign fac_k     = st_q.app_k;
    assign fac_m     = st_q.app_m;
    assign fac_p     = st_q.app_p;
    assign busy      = (st_q.ph != PH_IDLE);
    assign done      = st_q.done;
    assign lock_fail = st_q.fail;
    assign reject    = st_q.rej;

    // ---------------- assertions ----------------
    assert_p_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fac_p <= P_TOP);

    assert_reject_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy);

    assert_one_divider_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(fac_p) && !$stable(fac_m)));

    assert_nk_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fac_n) || !$stable(fac_k)) |-> ($stable(fac_p) && $stable(fac_m)));

    assert_m_drop_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fac_m < $past(fac_m)) |-> $past(pll_lock));

    assert_p_drop_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fac_p < $past(fac_p)) |->
            (($past(st_q.ph) == PH_LOCK && $past(pll_lock)) || $past(st_q.ph) == PH_M_DN));

    assert_target_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable({st_q.tgt_n, st_q.tgt_k, st_q.tgt_m, st_q.tgt_p})));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fail_no_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lock_fail |-> (!done && !busy));

endmodule

// File: tb/pll_factor_sequencer_bench.sv
`timescale 1ns/1ps
module pll_factor_sequencer_bench;

    localparam int NW = 5, KW = 2, MW = 2, PW = 3, LW = 8;
    localparam int LONG = 40, SHORT = 4, MDL_DLY = 25;

    // Stimulus table: requested N, K, M, P (applied in sequence).
    localparam int NV = 9;
    localparam int VN[NV] = '{10, 20, 20, 15, 25,  8,  8, 30, 7};
    localparam int VK[NV] = '{ 1,  1,  2,  2,  3,  0,  0,  3, 1};
    localparam int VM[NV] = '{ 1,  0,  0,  2,  0,  3,  3,  1, 0};
    localparam int VP[NV] = '{ 2,  0,  1,  1,  1,  0,  0,  3, 0};

    logic clk = 0, rst_n = 0, start = 0, pll_lock;
    logic [NW-1:0] req_n = '0;
    logic [KW-1:0] req_k = '0;
    logic [MW-1:0] req_m = '0;
    logic [PW-1:0] req_p = '0;
    logic [LW-1:0] lock_limit = 8'd200;
    logic [NW-1:0] fac_n;
    logic [KW-1:0] fac_k;
    logic [MW-1:0] fac_m;
    logic [PW-1:0] fac_p;
    logic busy, done, lock_fail, reject;

    always #2.5 clk = ~clk;

    pll_factor_sequencer #(
        .NW(NW), .KW(KW), .MW(MW), .PW(PW), .P_MAX(3),
        .SETTLE_LONG(LONG), .SETTLE_SHORT(SHORT), .LOCK_W(LW),
        .RST_N(16), .RST_K(0), .RST_M(0), .RST_P(0)
    ) u_pll_factor_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_n(req_n), .req_k(req_k), .req_m(req_m), .req_p(req_p),
        .lock_limit(lock_limit), .pll_lock(pll_lock),
        .fac_n(fac_n), .fac_k(fac_k), .fac_m(fac_m), .fac_p(fac_p),
        .busy(busy), .done(done), .lock_fail(lock_fail), .reject(reject)
    );

    // ---- behavioural PLL: VCO keeps its old rate until lock ----
    logic [NW-1:0] sn;
    logic [KW-1:0] sk;
    int  lcnt;
    logic kill_lock = 0;
    real vco;

    always @(posedge clk) begin
        if (!rst_n) begin
            sn <= 5'd16; sk <= 2'd0; lcnt <= 0; pll_lock <= 1'b1; vco <= 24.0 * 17.0;
        end else if ({fac_n, fac_k} != {sn, sk}) begin
            sn <= fac_n; sk <= fac_k; lcnt <= MDL_DLY; pll_lock <= 1'b0;
        end else if (kill_lock) begin
            pll_lock <= 1'b0;
        end else if (lcnt != 0) begin
            lcnt <= lcnt - 1;
        end else if (!pll_lock) begin
            pll_lock <= 1'b1;
            vco <= 24.0 * real'(int'(sn) + 1) * real'(int'(sk) + 1);
        end
    end

    // ---- bookkeeping ----
    int total = 0, fails = 0, cyc = 0;
    bit finished = 0;
    int ev_ty[32];
    int ev_t[32];
    int ev_n = 0;
    int busy_cnt, done_cnt, fail_cnt, rej_cnt, over_cnt, both_cnt, shape_bad;
    real bound = 1.0e9;
    logic [NW-1:0] ln;
    logic [KW-1:0] lk;
    logic [MW-1:0] lm;
    logic [PW-1:0] lp;
    logic pb;

    function automatic real freq(input int n, input int k, input int m, input int p);
        return 24.0 * real'(n + 1) * real'(k + 1) / real'((m + 1) * (1 << p));
    endfunction

    always @(negedge clk) begin
        real f;
        cyc++;
        if (rst_n) begin
            if (fac_p != lp && ev_n < 32) begin ev_ty[ev_n] = 1; ev_t[ev_n] = cyc; ev_n++; end
            if (fac_m != lm && ev_n < 32) begin ev_ty[ev_n] = 2; ev_t[ev_n] = cyc; ev_n++; end
            if ({fac_n, fac_k} != {ln, lk} && ev_n < 32) begin ev_ty[ev_n] = 3; ev_t[ev_n] = cyc; ev_n++; end
            if (fac_p != lp && fac_m != lm) both_cnt++;
            f = vco / real'((int'(fac_m) + 1) * (1 << fac_p));
            if (f > bound) over_cnt++;
            busy_cnt += int'(busy);
            done_cnt += int'(done);
            fail_cnt += int'(lock_fail);
            rej_cnt  += int'(reject);
            if (done && (busy || !pb)) shape_bad++;
        end
        ln = fac_n; lk = fac_k; lm = fac_m; lp = fac_p; pb = busy;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_counts();
        ev_n = 0; busy_cnt = 0; done_cnt = 0; fail_cnt = 0; rej_cnt = 0;
        over_cnt = 0; both_cnt = 0; shape_bad = 0;
    endtask

    task automatic run(input int n, input int k, input int m, input int p,
                       input int inj, output int blen);
        int waited;
        real fo, fn;
        fo = freq(int'(fac_n), int'(fac_k), int'(fac_m), int'(fac_p));
        fn = freq(n, k, m, p);
        bound = ((fo > fn) ? fo : fn) * 1.000001;
        clear_counts();
        req_n = NW'(n); req_k = KW'(k); req_m = MW'(m); req_p = PW'(p);
        start = 1'b1;
        tick();
        start = 1'b0;
        waited = 0;
        while (done_cnt == 0 && fail_cnt == 0 && waited < 20000) begin
            tick();
            waited++;
            if (inj != 0 && waited == inj) begin
                req_n = 5'd5; req_k = 2'd1; req_m = 2'd3; req_p = 3'd2;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(waited < 20000, "R11", "run ended", waited, 20000);
        blen = busy_cnt;
    endtask

    initial begin
        #750000;
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int len, lena, lenb, lenc;
        int pn, pk, pm, pp;
        int ex[8];
        int en;
        repeat (4) tick();
        // R1: reset state during and after reset
        check(fac_n == 5'd16 && fac_k == 0 && fac_m == 0 && fac_p == 0, "R1", "factors in reset",
              {fac_n, fac_k, fac_m, fac_p}, {5'd16, 2'd0, 2'd0, 3'd0});
        check(!busy && !done && !lock_fail && !reject, "R1", "flags in reset",
              {busy, done, lock_fail, reject}, 0);
        rst_n = 1'b1;
        repeat (3) tick();
        check(fac_n == 5'd16 && fac_m == 0 && fac_p == 0 && !busy && !done, "R1", "after reset",
              {fac_n, fac_m, fac_p, busy}, {5'd16, 2'd0, 3'd0, 1'b0});

        // Table walk
        for (int i = 0; i < NV; i++) begin
            pn = int'(fac_n); pk = int'(fac_k); pm = int'(fac_m); pp = int'(fac_p);
            run(VN[i], VK[i], VM[i], VP[i], 0, len);
            en = 0;
            if (VP[i] > pp) begin ex[en] = 1; en++; end
            if (VM[i] > pm) begin ex[en] = 2; en++; end
            if (VN[i] != pn || VK[i] != pk) begin ex[en] = 3; en++; end
            if (VM[i] < pm) begin ex[en] = 2; en++; end
            if (VP[i] < pp) begin ex[en] = 1; en++; end
            check(ev_n == en, "R7", $sformatf("vec %0d write count", i), ev_n, en);
            for (int j = 0; j < en && j < ev_n; j++)
                check(ev_ty[j] == ex[j], "R2 R3 R4 R5 R6", $sformatf("vec %0d write %0d kind", i, j),
                      ev_ty[j], ex[j]);
            for (int j = 0; j + 1 < ev_n; j++)
                if (ev_ty[j] != 3)
                    check(ev_t[j + 1] - ev_t[j] == LONG, (ev_ty[j] == 1) ? "R2" : "R3 R6",
                          $sformatf("vec %0d settle gap %0d", i, j), ev_t[j + 1] - ev_t[j], LONG);
            check(int'(fac_n) == VN[i] && int'(fac_k) == VK[i] && int'(fac_m) == VM[i] && int'(fac_p) == VP[i],
                  "R8", $sformatf("vec %0d final factors", i), {fac_n, fac_k, fac_m, fac_p},
                  {VN[i][4:0], VK[i][1:0], VM[i][1:0], VP[i][2:0]});
            check(both_cnt == 0, "R8", $sformatf("vec %0d dividers together", i), both_cnt, 0);
            check(done_cnt == 1 && shape_bad == 0 && fail_cnt == 0, "R11", $sformatf("vec %0d done pulse", i),
                  done_cnt, 1);
            check(over_cnt == 0, "R13", $sformatf("vec %0d overshoot cycles", i), over_cnt, 0);
        end

        // R7: run length grows by SETTLE_LONG per divider step
        run(12, 1, 0, 0, 0, lena);
        run(9, 1, 2, 2, 0, lenb);
        check(lenb == lena + 2 * LONG, "R7", "two raises add two settle waits", lenb, lena + 2 * LONG);
        run(12, 1, 0, 0, 0, lenc);
        check(lenc == lena + 2 * LONG, "R7", "two lowers add two settle waits", lenc, lena + 2 * LONG);
        check(fac_m == 0 && fac_p == 0, "R5", "dividers lowered", {fac_m, fac_p}, 0);

        // R9: invalid P refused
        for (int v = 4; v < 8; v += 3) begin
            clear_counts();
            req_n = 5'd3; req_k = 2'd3; req_m = 2'd3; req_p = PW'(v);
            start = 1'b1; tick(); start = 1'b0;
            repeat (5) tick();
            check(rej_cnt == 1, "R9", $sformatf("reject pulse p=%0d", v), rej_cnt, 1);
            check(busy_cnt == 0 && ev_n == 0, "R9", $sformatf("no activity p=%0d", v), busy_cnt + ev_n, 0);
            check(fac_n == 5'd12 && fac_p == 0, "R9", "factors kept", {fac_n, fac_p}, {5'd12, 3'd0});
        end

        // R10: start while busy ignored
        run(20, 0, 0, 0, 10, len);
        repeat (4) tick();
        check(fac_n == 5'd20 && fac_k == 0 && fac_m == 0 && fac_p == 0, "R10", "first request kept",
              {fac_n, fac_k, fac_m, fac_p}, {5'd20, 2'd0, 2'd0, 3'd0});
        check(done_cnt == 1 && !busy && rej_cnt == 0, "R10", "single run", done_cnt, 1);

        // R12: lock timeout
        run(20, 0, 2, 0, 0, len);
        kill_lock = 1'b1;
        lock_limit = 8'd10;
        run(6, 1, 0, 0, 0, len);
        tick();
        check(fail_cnt == 1 && done_cnt == 0, "R12", "fail without done", fail_cnt, 1);
        check(fac_n == 5'd6 && fac_k == 2'd1 && fac_m == 2'd2, "R12", "decrease skipped",
              {fac_n, fac_k, fac_m}, {5'd6, 2'd1, 2'd2});
        check(!busy, "R12", "back to idle", busy, 0);
        kill_lock = 1'b0;
        lock_limit = 8'd200;
        repeat (3) tick();
        run(6, 1, 0, 0, 0, len);
        check(done_cnt == 1 && fail_cnt == 0 && fac_m == 0, "R12", "recovers after timeout", fac_m, 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule